// File: doc/BRIEF.md
# DMA Interrupt Mask and Status Unit

This block keeps the interrupt state of an eight-channel DMA controller. The controller has five interrupt kinds: transfer done, block done, source transaction done, destination transaction done and fault. The DMA engine sends one-cycle event pulses, one per channel and per kind. Each pulse sets a sticky raw status bit. Each kind also has its own per-channel enable mask. The masked status of a kind is its raw bits ANDed with its mask. One interrupt line reports, one cycle late, whether any masked bit is set.

Software reaches the unit through a simple register port. A write strobe with address and data takes effect at the clock edge. Read data comes back combinationally for the address on the bus. A mask write carries a per-bit write-enable byte next to the mask byte, so software can change single enables without reading the register first. Status bits are cleared by writing ones to a separate clear address for each kind.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset every mask, raw status and masked status reads as zero, and `irq_o` is 0.
- R2: A read of the mask address of kind k (0x310 + 8k, kinds in the order transfer, block, source, destination, fault) returns the mask in bits [7:0] and zero in bits [31:8].
- R3: A write to the mask address of kind k changes mask bit n only when data bit 8+n is 1, and then loads data bit n. Other mask bits keep their value. For example, 0x0101 sets bit 0, and a write with bits [15:8] all zero changes nothing.
- R4: An event pulse on channel n of kind k sets raw bit n of that kind at the next clock edge. The bit stays set, and it reads back at 0x2C0 + 8k.
- R5: Writing data to the clear address of kind k (0x338 + 8k) clears each raw bit whose data bit is 1. Raw bits whose data bit is 0 are unchanged.
- R6: When an event pulse and a clear of the same raw bit happen in the same cycle, the bit ends up set.
- R7: A read of 0x2E8 + 8k returns the raw bits of kind k ANDed with the mask of kind k.
- R8: `irq_o` equals the OR of all masked status bits of all kinds as they were one clock cycle earlier.
- R9: Writes to the raw status and masked status addresses have no effect on any state.
- R10: Reads of any address other than the raw, masked and mask addresses, including the clear addresses, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| evt_xfer_done | input | 8 | Per-channel transfer-done pulses |
| evt_blk_done | input | 8 | Per-channel block-done pulses |
| evt_src_done | input | 8 | Per-channel source-transaction-done pulses |
| evt_dst_done | input | 8 | Per-channel destination-transaction-done pulses |
| evt_fault | input | 8 | Per-channel fault pulses |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The hardest case to reach is an event pulse and a clear of the same bit in the same cycle. It happens rarely under ordinary traffic, because events are sparse and clears go to one kind at a time. The bench creates it directly by clearing a bit in the very step that pulses it. The random phase then mixes dense event pulses on all kinds with clears that carry random data, so overlaps also occur by chance. Partial mask writes are also made random: each write-enable byte is drawn independently of its data byte, so writes with no enables and writes with enables only on bits that are already set both occur often.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

   localparam int NUM_KIND    = 5;
   localparam int KIND_STRIDE = 8;

   // Kind order fixes the address of each register group.
   typedef enum logic [2:0] {
      KIND_XFER = 3'd0,
      KIND_BLK  = 3'd1,
      KIND_SRC  = 3'd2,
      KIND_DST  = 3'd3,
      KIND_FLT  = 3'd4
   } irq_kind_e;

   localparam int RAW_BASE  = 'h2C0;
   localparam int MSKD_BASE = 'h2E8;
   localparam int MASK_BASE = 'h310;
   localparam int CLR_BASE  = 'h338;

   function automatic int kind_addr(input int base, input int kind);
      return base + kind * KIND_STRIDE;
   endfunction

endpackage

// File: rtl/dma_irq_mask_reg.sv
module dma_irq_mask_reg #(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 32,
   parameter int WE_OFS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   output logic [NUM_CH-1:0] mask_q
);

   logic [NUM_CH-1:0] we_bits;
   logic [NUM_CH-1:0] val_bits;

   assign we_bits  = wdata[WE_OFS +: NUM_CH];
   assign val_bits = wdata[NUM_CH-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_hit) begin
         for (int n = 0; n < NUM_CH; n++) begin
            if (we_bits[n]) mask_q[n] <= val_bits[n];
         end
      end
   end

   // R3: no enabled bit, no change
   p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit || we_bits == '0) |=> $stable(mask_q));

   // R3: enabled bits take the written value
   p_mask_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> ((mask_q & $past(we_bits)) == ($past(val_bits) & $past(we_bits))));

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt,
   input  logic              clr_hit,
   input  logic [NUM_CH-1:0] clr_bits,
   output logic [NUM_CH-1:0] raw_q
);

   logic [NUM_CH-1:0] clr_eff;

   assign clr_eff = clr_hit ? clr_bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= '0;
      else        raw_q <= (raw_q & ~clr_eff) | evt;
   end

   // R4, R6: a pulse always lands, even against a clear
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt != '0) |=> ((raw_q & $past(evt)) == $past(evt)));

   // R5: cleared bits without a pulse drop
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && evt == '0) |=> ((raw_q & $past(clr_bits)) == '0));

   // R4: set bits stay set without a clear
   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_hit) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

endmodule

// File: rtl/dma_irq_rd_mux.sv
module dma_irq_rd_mux
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32
) (
   input  logic [ADDR_W-1:0]                bus_addr,
   input  logic [NUM_KIND-1:0][NUM_CH-1:0] raw,
   input  logic [NUM_KIND-1:0][NUM_CH-1:0] mskd,
   input  logic [NUM_KIND-1:0][NUM_CH-1:0] mask,
   output logic [DATA_W-1:0]                rdata
);

   logic [NUM_KIND-1:0] raw_sel, mskd_sel, mask_sel;

   for (genvar k = 0; k < NUM_KIND; k++) begin : g_dec
      localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(kind_addr(RAW_BASE, k));
      localparam logic [ADDR_W-1:0] A_MSKD = ADDR_W'(kind_addr(MSKD_BASE, k));
      localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(kind_addr(MASK_BASE, k));
      assign raw_sel[k]  = (bus_addr == A_RAW);
      assign mskd_sel[k] = (bus_addr == A_MSKD);
      assign mask_sel[k] = (bus_addr == A_MASK);
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_KIND; k++) begin
         if (raw_sel[k])  rdata[NUM_CH-1:0] = rdata[NUM_CH-1:0] | raw[k];
         if (mskd_sel[k]) rdata[NUM_CH-1:0] = rdata[NUM_CH-1:0] | mskd[k];
         if (mask_sel[k]) rdata[NUM_CH-1:0] = rdata[NUM_CH-1:0] | mask[k];
      end
   end

   // R10: at most one register answers an address
   p_one_sel_r10: assert final ($countones({raw_sel, mskd_sel, mask_sel}) <= 1);

endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int WE_OFS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] evt_xfer_done,
   input  logic [NUM_CH-1:0] evt_blk_done,
   input  logic [NUM_CH-1:0] evt_src_done,
   input  logic [NUM_CH-1:0] evt_dst_done,
   input  logic [NUM_CH-1:0] evt_fault,
   output logic              irq_o
);

   localparam int TOP_ADDR = CLR_BASE + (NUM_KIND - 1) * KIND_STRIDE;

   if (NUM_CH < 1 || NUM_CH > WE_OFS) begin : g_chk_ch
      $error("dma_irq_unit: NUM_CH must be between 1 and WE_OFS");
   end
   if (WE_OFS + NUM_CH > DATA_W) begin : g_chk_data
      $error("dma_irq_unit: enable field does not fit in DATA_W");
   end
   if (TOP_ADDR >= (1 << ADDR_W)) begin : g_chk_addr
      $error("dma_irq_unit: ADDR_W too narrow for the register map");
   end

   logic [NUM_KIND-1:0][NUM_CH-1:0] evt_all;
   logic [NUM_KIND-1:0][NUM_CH-1:0] raw_all;
   logic [NUM_KIND-1:0][NUM_CH-1:0] mask_all;
   logic [NUM_KIND-1:0][NUM_CH-1:0] mskd_all;
   logic                            any_mskd;
   logic                            irq_q;

   assign evt_all[KIND_XFER] = evt_xfer_done;
   assign evt_all[KIND_BLK]  = evt_blk_done;
   assign evt_all[KIND_SRC]  = evt_src_done;
   assign evt_all[KIND_DST]  = evt_dst_done;
   assign evt_all[KIND_FLT]  = evt_fault;

   for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
      localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(kind_addr(MASK_BASE, k));
      localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(kind_addr(CLR_BASE, k));

      logic mask_wr, clr_wr;
      assign mask_wr = bus_wr && (bus_addr == A_MASK);
      assign clr_wr  = bus_wr && (bus_addr == A_CLR);

      dma_irq_mask_reg #(
         .NUM_CH (NUM_CH),
         .DATA_W (DATA_W),
         .WE_OFS (WE_OFS)
      ) u_mask (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_hit (mask_wr),
         .wdata  (bus_wdata),
         .mask_q (mask_all[k])
      );

      dma_irq_status #(
         .NUM_CH (NUM_CH)
      ) u_stat (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt      (evt_all[k]),
         .clr_hit  (clr_wr),
         .clr_bits (bus_wdata[NUM_CH-1:0]),
         .raw_q    (raw_all[k])
      );

      assign mskd_all[k] = raw_all[k] & mask_all[k];
   end

   assign any_mskd = |mskd_all;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= any_mskd;
   end

   assign irq_o = irq_q;

   dma_irq_rd_mux #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_rd (
      .bus_addr (bus_addr),
      .raw      (raw_all),
      .mskd     (mskd_all),
      .mask     (mask_all),
      .rdata    (bus_rdata)
   );

   // R8: the interrupt line trails the masked status by one cycle
   p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (irq_o == $past(any_mskd)));

   // R7, R8: with every mask clear, the line drops on the next cycle
   p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_all == '0) |=> !irq_o);

endmodule

// File: tb/tb_dma_irq_unit.sv
module tb_dma_irq_unit;

   localparam int NK = 5;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [11:0] addr;
   logic        wr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic [7:0]  ev [NK];
   logic        irq;

   always #4 clk = ~clk;

   dma_irq_unit dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_addr      (addr),
      .bus_wr        (wr),
      .bus_wdata     (wdata),
      .bus_rdata     (rdata),
      .evt_xfer_done (ev[0]),
      .evt_blk_done  (ev[1]),
      .evt_src_done  (ev[2]),
      .evt_dst_done  (ev[3]),
      .evt_fault     (ev[4]),
      .irq_o         (irq)
   );

   logic [7:0] m_mask [NK];
   logic [7:0] m_raw  [NK];
   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      for (int k = 0; k < NK; k++) begin
         if (a == 12'h2C0 + 12'(8*k)) return {24'h0, m_raw[k]};
         if (a == 12'h2E8 + 12'(8*k)) return {24'h0, m_raw[k] & m_mask[k]};
         if (a == 12'h310 + 12'(8*k)) return {24'h0, m_mask[k]};
      end
      return 32'h0;
   endfunction

   function automatic logic exp_irq();
      logic r = 1'b0;
      for (int k = 0; k < NK; k++) r |= |(m_raw[k] & m_mask[k]);
      return r;
   endfunction

   function automatic string tag_of(input logic [11:0] a);
      if (a >= 12'h2C0 && a <= 12'h2E0) return "R4 R5 R6 raw read";
      if (a >= 12'h2E8 && a <= 12'h308) return "R7 masked read";
      if (a >= 12'h310 && a <= 12'h330) return "R2 R3 mask read";
      return "R10 unmapped read";
   endfunction

   // One cycle: drive at negedge, check read before the edge, irq after it.
   task automatic step(input logic [11:0] a, input logic w, input logic [31:0] d,
                       input logic [39:0] evts, input string tag);
      logic irq_e;
      @(negedge clk);
      addr  = a;
      wr    = w;
      wdata = d;
      for (int k = 0; k < NK; k++) ev[k] = evts[8*k +: 8];
      #1;
      chk(tag, rdata, exp_read(a));
      irq_e = exp_irq();
      for (int k = 0; k < NK; k++) begin
         if (w && a == 12'h310 + 12'(8*k))
            m_mask[k] = (m_mask[k] & ~d[15:8]) | (d[7:0] & d[15:8]);
         if (w && a == 12'h338 + 12'(8*k))
            m_raw[k] = m_raw[k] & ~d[7:0];
         m_raw[k] = m_raw[k] | evts[8*k +: 8];
      end
      @(posedge clk);
      #1;
      chk("R8 irq", {31'h0, irq}, {31'h0, irq_e});
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0;
      addr  = '0;
      wr    = 1'b0;
      wdata = '0;
      for (int k = 0; k < NK; k++) begin
         ev[k]     = '0;
         m_mask[k] = '0;
         m_raw[k]  = '0;
      end
      repeat (3) @(posedge clk);
      #1;
      chk("R1 irq in reset", {31'h0, irq}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: everything reads zero after reset
      for (int k = 0; k < NK; k++) begin
         step(12'h2C0 + 12'(8*k), 1'b0, 0, 40'h0, "R1 raw");
         step(12'h2E8 + 12'(8*k), 1'b0, 0, 40'h0, "R1 masked");
         step(12'h310 + 12'(8*k), 1'b0, 0, 40'h0, "R1 mask");
      end

      // R3: single-bit set, no-enable write, partial enables
      step(12'h310, 1'b1, 32'h0000_0101, 40'h0, "R3 write");
      step(12'h310, 1'b0, 0, 40'h0, "R3 0x0101 sets bit0");
      step(12'h310, 1'b1, 32'h0000_00FF, 40'h0, "R3 write");
      step(12'h310, 1'b0, 0, 40'h0, "R3 no enables keeps mask");
      step(12'h310, 1'b1, 32'h0000_FE00, 40'h0, "R3 write");
      step(12'h310, 1'b0, 0, 40'h0, "R3 partial enables");
      // R2: upper read bits zero
      step(12'h328, 1'b1, 32'hFFFF_FFFF, 40'h0, "R2 write");
      step(12'h328, 1'b0, 0, 40'h0, "R2 upper bits zero");

      // R4: event sets and holds
      step(12'h2C0, 1'b0, 0, 40'h08, "R4 read");
      step(12'h2C0, 1'b0, 0, 40'h0, "R4 raw bit3 set");
      step(12'h2C0, 1'b0, 0, 40'h0, "R4 raw bit3 held");
      // R7, R8: unmask bit3 of transfer kind
      step(12'h2E8, 1'b0, 0, 40'h0, "R7 masked zero");
      step(12'h310, 1'b1, 32'h0000_0808, 40'h0, "R7 write");
      step(12'h2E8, 1'b0, 0, 40'h0, "R7 masked bit3");
      step(12'h2E8, 1'b0, 0, 40'h0, "R8 irq high");
      // R5: clear
      step(12'h338, 1'b1, 32'h0000_0008, 40'h0, "R5 clear");
      step(12'h2C0, 1'b0, 0, 40'h0, "R5 raw cleared");
      step(12'h2C0, 1'b0, 0, 40'h0, "R8 irq low");
      // R6: set and clear in the same cycle
      step(12'h340, 1'b1, 32'h0000_0004, 40'h04_00, "R6 clear with event");
      step(12'h2C8, 1'b0, 0, 40'h0, "R6 set wins");
      // R9: writes to status addresses ignored
      step(12'h2C8, 1'b1, 32'hFFFF_FFFF, 40'h0, "R9 write raw");
      step(12'h2F0, 1'b1, 32'hFFFF_FFFF, 40'h0, "R9 write masked");
      step(12'h2C8, 1'b0, 0, 40'h0, "R9 raw unchanged");
      step(12'h318, 1'b0, 0, 40'h0, "R9 mask unchanged");
      // R10: unmapped and clear addresses read zero
      step(12'h000, 1'b0, 0, 40'h0, "R10 addr 0");
      step(12'h2C4, 1'b0, 0, 40'h0, "R10 misaligned");
      step(12'h358, 1'b0, 0, 40'h0, "R10 clear addr read");

      // Random mix
      for (int i = 0; i < 4000; i++) begin
         int unsigned sel  = $urandom_range(0, 9);
         int unsigned kind = $urandom_range(0, NK-1);
         logic [11:0] a;
         logic        w;
         logic [31:0] d;
         logic [39:0] e;
         d = $urandom;
         e = '0;
         for (int k = 0; k < NK; k++)
            if ($urandom_range(0, 3) == 0) e[8*k +: 8] = 8'($urandom) & 8'($urandom);
         case (sel)
            0, 1:    begin a = 12'h310 + 12'(8*kind); w = 1'b1; end
            2, 3:    begin a = 12'h338 + 12'(8*kind); w = 1'b1; end
            4:       begin a = 12'h2C0 + 12'(8*kind); w = 1'b1; end
            5:       begin a = 12'h2C0 + 12'(8*kind); w = 1'b0; end
            6:       begin a = 12'h2E8 + 12'(8*kind); w = 1'b0; end
            7:       begin a = 12'h310 + 12'(8*kind); w = 1'b0; end
            8:       begin a = 12'($urandom); w = 1'b0; end
            default: begin a = 12'h2E8 + 12'(8*kind); w = 1'b1; end
         endcase
         if (sel <= 1 && $urandom_range(0, 3) == 0) d[15:8] = '0;
         step(a, w, d, e, tag_of(a));
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule